// File: doc/BRIEF.md
# Polynomial Code Encoder and Checker

This block protects a GF(2) operand with a non-cyclic polynomial linear code. The encoder turns an M-bit value U into the N-bit codeword U(x)·g(x), where N = M + R and g(x) is any degree-R generator whose constant and top coefficients are both 1. The checker takes an N-bit word, which may be corrupted, and divides it by g(x) in one combinational pass. It returns the M-bit quotient as the decoded operand and raises an error flag whenever the R-bit remainder is nonzero.

Both functions are unrolled logic. A thin registered wrapper puts them behind one clock stage, qualified by a valid strobe. The encoder and the checker have separate input buses, so a datapath can encode one operand and check another in the same cycle. Multipliers or adders that work on encoded operands feed the checker at their outputs. Because the code is linear, sums and bit-scaled copies of codewords stay codewords.

Top module: `pcode_unit`

## Requirements
- R1: With the default generator g(x) = x^8 + x^2 + x + 1 (M = 16, R = 8), the encoded output equals the carry-less product of the operand and g(x).
- R2: Bit 0 of every codeword equals bit 0 of the operand, and bit N-1 equals bit M-1 of the operand.
- R3: A word that is a valid codeword decodes to the operand it was built from, with the error flag at 0.
- R4: For any word, the quotient Q and remainder S satisfy word = Q·g XOR S. The error flag is 1 exactly when S is nonzero. Bits [R-1:0] of the word lie in the remainder field.
- R5: Flipping any single bit of a codeword sets the error flag.
- R6: An error pattern that is a multiple of g(x) goes undetected. Adding g(x)·x^k to the codeword of U gives an error flag of 0 and a quotient of U XOR x^k.
- R7: Encoding is linear: the code of (a XOR b) equals the XOR of the codes of a and b.
- R8: valid_out is 1 in the cycle after valid_in is 1, and 0 in the cycle after valid_in is 0.
- R9: While valid_in is 0, the encoded output, decoded output and error flag keep their values.
- R10: Synchronous active-high reset clears valid_out, enc_out, dec_out and err_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Both input buses are valid this cycle |
| enc_in | input | M | Operand to encode |
| chk_in | input | N | Word to check and decode |
| valid_out | output | 1 | Registered results are fresh |
| enc_out | output | N | Codeword of enc_in |
| dec_out | output | M | Quotient of chk_in by g(x) |
| err_out | output | 1 | Nonzero remainder seen on chk_in |

## Verification
Encoding and checking share one capture edge. The bench loads both buses in every vector, with unrelated contents on each: enc_in takes one table entry while chk_in carries the codeword of the next entry. Both registered results are then judged in the same sampling slot against separately computed expectations. This exposes any crosstalk between the two datapaths or any mix-up of their widths. Corrupted words (single-bit flips, remainder-only noise and multiples of g) are also sent while the encoder works on unrelated data.

// File: rtl/pcode_pkg.sv
`timescale 1ns/1ps
package pcode_pkg;
    // Default code shape: 16 data bits, degree-8 generator.
    localparam int DEF_M = 16;
    localparam int DEF_R = 8;
    // x^8 + x^2 + x + 1 : constant and leading terms set.
    localparam logic [DEF_R:0] DEF_GEN = 9'h107;

    // Status that travels alongside the registered datapath.
    typedef struct packed {
        logic valid;
        logic err;
    } stage_flags_t;
endpackage

// File: rtl/pcode_encoder.sv
`timescale 1ns/1ps
module pcode_encoder #(
    parameter int M = pcode_pkg::DEF_M,
    parameter int R = pcode_pkg::DEF_R,
    parameter logic [R:0] GEN = pcode_pkg::DEF_GEN,
    localparam int N = M + R
) (
    input  logic [M-1:0] op,
    output logic [N-1:0] code
);
    localparam logic [N-1:0] GEN_EXT = {{(N-R-1){1'b0}}, GEN};

    // Carry-less product: XOR of the generator shifted by each set operand bit.
    always_comb begin
        code = '0;
        for (int i = 0; i < M; i++) begin
            if (op[i]) code = code ^ (GEN_EXT << i);
        end
    end

    // The generator has unit end coefficients, so the codeword ends mirror the operand ends.
    always_comb begin
        p_ends_r2: assert (code[0] == op[0] && code[N-1] == op[M-1]);
    end
endmodule

// File: rtl/pcode_checker.sv
`timescale 1ns/1ps
module pcode_checker #(
    parameter int M = pcode_pkg::DEF_M,
    parameter int R = pcode_pkg::DEF_R,
    parameter logic [R:0] GEN = pcode_pkg::DEF_GEN,
    localparam int N = M + R
) (
    input  logic [N-1:0] word,
    output logic [M-1:0] quot,
    output logic [R-1:0] rem,
    output logic         err
);
    localparam logic [N-1:0] GEN_EXT = {{(N-R-1){1'b0}}, GEN};

    logic [N-1:0] work;

    // Unrolled long division, one quotient bit per step from the top down.
    always_comb begin
        work = word;
        quot = '0;
        for (int s = N - 1; s >= R; s--) begin
            if (work[s]) begin
                quot[s-R] = 1'b1;
                work = work ^ (GEN_EXT << (s - R));
            end
        end
        rem = work[R-1:0];
        err = |work[R-1:0];
    end

    // Division identity: word == quot*g XOR rem, with rebuild done by shifts of the quotient.
    logic [N-1:0] rebuilt;
    always_comb begin
        rebuilt = {{M{1'b0}}, rem};
        for (int j = 0; j <= R; j++) begin
            if (GEN[j]) rebuilt = rebuilt ^ ({{R{1'b0}}, quot} << j);
        end
        p_div_identity_r4: assert (rebuilt == word);
    end
endmodule

// File: rtl/pcode_unit.sv
`timescale 1ns/1ps
module pcode_unit #(
    parameter int M = pcode_pkg::DEF_M,
    parameter int R = pcode_pkg::DEF_R,
    parameter logic [R:0] GEN = pcode_pkg::DEF_GEN,
    localparam int N = M + R
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_in,
    input  logic [M-1:0] enc_in,
    input  logic [N-1:0] chk_in,
    output logic         valid_out,
    output logic [N-1:0] enc_out,
    output logic [M-1:0] dec_out,
    output logic         err_out
);
    import pcode_pkg::*;

    logic [N-1:0] code_c;
    logic [M-1:0] quot_c;
    logic [R-1:0] rem_c;
    logic         err_c;

    pcode_encoder #(.M(M), .R(R), .GEN(GEN)) u_enc (
        .op   (enc_in),
        .code (code_c)
    );

    pcode_checker #(.M(M), .R(R), .GEN(GEN)) u_chk (
        .word (chk_in),
        .quot (quot_c),
        .rem  (rem_c),
        .err  (err_c)
    );

    stage_flags_t flags_q;
    logic [N-1:0] code_q;
    logic [M-1:0] quot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            code_q  <= '0;
            quot_q  <= '0;
        end else begin
            flags_q.valid <= valid_in;
            if (valid_in) begin
                flags_q.err <= err_c;
                code_q      <= code_c;
                quot_q      <= quot_c;
            end
        end
    end

    assign valid_out = flags_q.valid;
    assign enc_out   = code_q;
    assign dec_out   = quot_q;
    assign err_out   = flags_q.err;

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(enc_out) && $stable(dec_out) && $stable(err_out)));
endmodule

// File: tb/sim_pcode_unit.sv
`timescale 1ns/1ps
module sim_pcode_unit;
    localparam int M = 16;
    localparam int R = 8;
    localparam int N = M + R;
    localparam logic [R:0] G = 9'h107;
    localparam int NV = 8;
    localparam logic [M-1:0] VEC [NV] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF,
                                          16'hA5A5, 16'h1234, 16'h0F0F, 16'h7FFE};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_in = 1'b0;
    logic [M-1:0] enc_in = '0;
    logic [N-1:0] chk_in = '0;
    logic valid_out;
    logic [N-1:0] enc_out;
    logic [M-1:0] dec_out;
    logic err_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pcode_unit u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .enc_in(enc_in), .chk_in(chk_in),
        .valid_out(valid_out), .enc_out(enc_out), .dec_out(dec_out), .err_out(err_out)
    );

    // Reference codeword built from the requirement (R1): product with g(x).
    function automatic logic [N-1:0] ref_code(input logic [M-1:0] u);
        logic [N-1:0] acc = '0;
        for (int k = 0; k <= R; k++)
            if (G[k]) acc = acc ^ ({{R{1'b0}}, u} << k);
        return acc;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present both buses for one capture edge, then sample after it.
    task automatic apply(input logic [M-1:0] u, input logic [N-1:0] w);
        @(negedge clk);
        enc_in = u;
        chk_in = w;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cw;
        logic [N-1:0] hold_e;
        logic [M-1:0] hold_d;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(valid_out == 1'b0 && enc_out == '0 && dec_out == '0 && err_out == 1'b0,
              "R10", {7'd0, valid_out, enc_out}, 32'd0);
        rst = 1'b0;

        // Table walk: encoder on VEC[i], checker on codeword of VEC[i+1], same cycle.
        for (int i = 0; i < NV; i++) begin
            logic [M-1:0] other;
            other = VEC[(i + 1) % NV];
            apply(VEC[i], ref_code(other));
            check(enc_out == ref_code(VEC[i]), "R1", 32'(enc_out), 32'(ref_code(VEC[i])));
            check(enc_out[0] == VEC[i][0] && enc_out[N-1] == VEC[i][M-1], "R2",
                  {30'd0, enc_out[N-1], enc_out[0]}, {30'd0, VEC[i][M-1], VEC[i][0]});
            check(dec_out == other && !err_out, "R3", {15'd0, err_out, dec_out}, {16'd0, other});
            check(valid_out == 1'b1, "R8", 32'(valid_out), 32'd1);
        end
        @(negedge clk);
        check(valid_out == 1'b0, "R8", 32'(valid_out), 32'd0);

        // R4: noise confined to the remainder field keeps the quotient, sets the flag
        cw = ref_code(16'h1234) ^ 24'h000005;
        apply(16'h0000, cw);
        check(dec_out == 16'h1234 && err_out, "R4", {15'd0, err_out, dec_out}, {15'd0, 1'b1, 16'h1234});
        apply(16'h0000, 24'h000001);
        check(dec_out == 16'h0000 && err_out, "R4", {15'd0, err_out, dec_out}, 32'h0001_0000);
        apply(16'h0000, 24'h000100);
        check(dec_out == 16'h0001 && err_out, "R4", {15'd0, err_out, dec_out}, 32'h0001_0001);

        // R5: every single-bit flip of a codeword is caught
        for (int b = 0; b < N; b++) begin
            apply(16'hA5A5, ref_code(16'hA5A5) ^ (24'd1 << b));
            check(err_out == 1'b1, "R5", 32'(b), 32'd1);
        end

        // R6: error equal to g(x)*x^3 escapes and shifts the quotient
        apply(16'h0000, ref_code(16'h0F0F) ^ ({15'd0, G} << 3));
        check(!err_out && dec_out == (16'h0F0F ^ 16'h0008), "R6",
              {15'd0, err_out, dec_out}, {16'd0, 16'h0F07});

        // R7: linearity of the encoder
        begin
            logic [N-1:0] ea;
            logic [N-1:0] eb;
            apply(16'h1234, '0); ea = enc_out;
            apply(16'hA5A5, '0); eb = enc_out;
            apply(16'h1234 ^ 16'hA5A5, '0);
            check(enc_out == (ea ^ eb), "R7", 32'(enc_out), 32'(ea ^ eb));
        end

        // R9: outputs hold while valid_in is low and inputs move
        apply(16'hFFFF, ref_code(16'h7FFE) ^ 24'h000002);
        hold_e = enc_out;
        hold_d = dec_out;
        @(negedge clk);
        enc_in = 16'h0001;
        chk_in = ref_code(16'h8000);
        repeat (3) @(negedge clk);
        check(enc_out == hold_e && dec_out == hold_d && err_out == 1'b1, "R9",
              32'(enc_out), 32'(hold_e));

        // R10: reset mid-stream clears everything
        rst = 1'b1;
        @(negedge clk);
        check(valid_out == 1'b0 && enc_out == '0 && dec_out == '0 && err_out == 1'b0,
              "R10", {7'd0, valid_out, enc_out}, 32'd0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule